// File: doc/BRIEF.md
# Private Interrupt State Register Bank

This block keeps the per-processor state of 32 private interrupts: enable, pending, active, group, group modifier and the edge/level configuration. Software reaches it through a simple 32-bit register port whose every request carries a secure or non-secure attribute. A global "security disabled" input changes how that attribute is honoured. The bank drives its state vectors straight to a downstream priority arbiter. It pulses a strobe whenever stored state changes, so that the arbiter knows to re-evaluate.

When security is enabled, a non-secure request may only see and change interrupts whose group bit is 1. Every other bit reads as zero and ignores writes. Enable, pending and active each have a set view and a clear view. The configuration state is exposed as two 32-bit registers with two bits per interrupt, of which only the odd bit carries information. The pending view also reports the live input level of interrupts configured as level-sensitive.

Top module: `irq_state_bank`

## Requirements
- R1: The access mask is the group register when `req_secure`=0 and `sec_disable`=0, and all ones otherwise. Bits outside the mask read as 0 and ignore writes on the enable, pending, active and configuration registers.
- R2: Each of enable (set 0x04, clear 0x08), pending latch (set 0x0C, clear 0x10) and active (set 0x14, clear 0x18) has two views. Writing 1s to the set view ORs in the masked bits, and writing 1s to the clear view removes them. Both views read the same masked bitmap.
- R3: A read of either pending view returns (latch OR (`irq_level` AND NOT edge)) AND mask. `pending_o` gives the same value without the mask.
- R4: The group register (0x00) reads 0 and ignores writes for a non-secure request while `sec_disable`=0.
- R5: The group-modifier register (0x24) and the non-secure access register (0x28) read 0 and ignore writes unless `req_secure`=1 and `sec_disable`=0.
- R6: Configuration register 0x1C covers interrupts 0–15 and 0x20 covers 16–31. Interrupt i's edge bit (1 = edge) reads at bit 2*(i mod 16)+1, and the even bits read 0. Interrupts 0–15 are always edge-triggered, so 0x1C reads 0xAAAAAAAA under a full mask.
- R7: Writes to 0x1C are ignored. A write to 0x20 takes bit 2k+1 as the new edge bit of interrupt 16+k, updating only the bits allowed by the mask.
- R8: Every request gets `rsp_valid` in the following cycle. A write returns data 0. An offset not listed here returns `rsp_err`=1 with data 0 and changes nothing.
- R9: After reset, enable, pending latch, active, group, group modifier and the non-secure access register are zero, and interrupts 16–31 are level-sensitive (`edge_o`=0x0000FFFF).
- R10: `update_o` is high for exactly the cycle after a write that changed enable, pending latch, active, group, group modifier or edge configuration, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_disable | input | 1 | Global security-disabled setting |
| irq_level | input | 32 | Current level of each interrupt input |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Request carries the secure attribute |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unknown offset |
| enable_o | output | 32 | Enable bitmap |
| pending_o | output | 32 | Effective pending (latch or live level) |
| active_o | output | 32 | Active bitmap |
| group_o | output | 32 | Group bitmap |
| grpmod_o | output | 32 | Group-modifier bitmap |
| edge_o | output | 32 | Edge-triggered configuration per interrupt |
| update_o | output | 1 | Pulse after any change of arbiter-visible state |

## Verification
Corrupted state in this block shows up at the ports quickly. A wrongly masked set or clear shows on `enable_o`, `pending_o` or `active_o` in the cycle after the write. The same fault also appears in the next read response, where the group mask can hide it from one security view but not the other. For that reason each mutation is read back through both a secure and a non-secure request. Faults in packing the configuration bits or in merging the live level only appear once a level-sensitive interrupt has its input driven. The tests therefore exercise both edge and level configurations with the level held high. A spurious or missing change strobe is visible on `update_o` one cycle after each write, including writes that are ignored.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_GROUP  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_EN_SET = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_PD_SET = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_PD_CLR = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_AC_SET = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_AC_CLR = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CFG_LO = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CFG_HI = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_GMOD   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_NSAC   = 8'h28;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_GROUP, SEL_EN_SET, SEL_EN_CLR, SEL_PD_SET, SEL_PD_CLR,
    SEL_AC_SET, SEL_AC_CLR, SEL_CFG_LO, SEL_CFG_HI, SEL_GMOD, SEL_NSAC
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_GROUP:  s = SEL_GROUP;
      OFF_EN_SET: s = SEL_EN_SET;
      OFF_EN_CLR: s = SEL_EN_CLR;
      OFF_PD_SET: s = SEL_PD_SET;
      OFF_PD_CLR: s = SEL_PD_CLR;
      OFF_AC_SET: s = SEL_AC_SET;
      OFF_AC_CLR: s = SEL_AC_CLR;
      OFF_CFG_LO: s = SEL_CFG_LO;
      OFF_CFG_HI: s = SEL_CFG_HI;
      OFF_GMOD:   s = SEL_GMOD;
      OFF_NSAC:   s = SEL_NSAC;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/irqb_access_mask.sv
module irqb_access_mask #(
  parameter int unsigned N = 32
) (
  input  logic         secure,
  input  logic         sec_disable,
  input  logic [N-1:0] group_q,
  output logic [N-1:0] mask,
  output logic         ns_limited,
  output logic         secure_only_ok
);
  // Non-secure request while security is on: only group-1 interrupts visible.
  assign ns_limited     = !secure && !sec_disable;
  assign secure_only_ok = secure && !sec_disable;
  assign mask           = ns_limited ? group_q : {N{1'b1}};
endmodule

// File: rtl/irqb_setclr_bitmap.sv
module irqb_setclr_bitmap #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] mask,
  output logic [N-1:0] bits_q,
  output logic         changed
);
  logic [N-1:0] bits_d;
  logic [N-1:0] eff;

  assign eff = wbits & mask;

  always_comb begin
    bits_d = bits_q;
    if (set_en)      bits_d = bits_q | eff;
    else if (clr_en) bits_d = bits_q & ~eff;
  end

  assign changed = (bits_d != bits_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bits_q <= '0;
    else if (set_en || clr_en) bits_q <= bits_d;
  end
endmodule

// File: rtl/irqb_cfg_bank.sv
module irqb_cfg_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hi,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] mask,
  output logic [N-1:0] edge_q,
  output logic [N-1:0] rd_lo,
  output logic [N-1:0] rd_hi,
  output logic         changed
);
  localparam int unsigned HALF = N / 2;

  logic [HALF-1:0] hi_q;
  logic [HALF-1:0] hi_d;
  logic [HALF-1:0] packed_w;
  logic [HALF-1:0] hi_mask;
  logic [N-1:0]    vis;

  assign hi_mask = mask[N-1:HALF];
  assign edge_q  = {hi_q, {HALF{1'b1}}};
  assign vis     = edge_q & mask;

  for (genvar k = 0; k < HALF; k++) begin : g_pack
    assign packed_w[k]     = wdata[2*k+1];
    assign rd_lo[2*k]      = 1'b0;
    assign rd_lo[2*k+1]    = vis[k];
    assign rd_hi[2*k]      = 1'b0;
    assign rd_hi[2*k+1]    = vis[HALF+k];
  end

  always_comb begin
    hi_d = hi_q;
    if (wr_hi) hi_d = (hi_q & ~hi_mask) | (packed_w & hi_mask);
  end

  assign changed = (hi_d != hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_hi) hi_q <= hi_d;
  end
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irqb_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_disable,
  input  logic [NUM_IRQ-1:0]   irq_level,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_secure,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [NUM_IRQ-1:0]   req_wdata,
  output logic                 rsp_valid,
  output logic [NUM_IRQ-1:0]   rsp_rdata,
  output logic                 rsp_err,
  output logic [NUM_IRQ-1:0]   enable_o,
  output logic [NUM_IRQ-1:0]   pending_o,
  output logic [NUM_IRQ-1:0]   active_o,
  output logic [NUM_IRQ-1:0]   group_o,
  output logic [NUM_IRQ-1:0]   grpmod_o,
  output logic [NUM_IRQ-1:0]   edge_o,
  output logic                 update_o
);
  localparam int unsigned NBM = 3; // enable, pending latch, active

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  reg_sel_e sel;
  logic     wr, rd;
  assign sel = decode_offset(req_addr);
  assign wr  = req_valid && req_write && (sel != SEL_NONE);
  assign rd  = req_valid && !req_write;

  logic [NUM_IRQ-1:0] group_q, grpmod_q, nsac_q;
  logic [NUM_IRQ-1:0] mask;
  logic               ns_limited, secure_only_ok;

  irqb_access_mask #(.N(NUM_IRQ)) u_mask (
    .secure(req_secure), .sec_disable(sec_disable), .group_q(group_q),
    .mask(mask), .ns_limited(ns_limited), .secure_only_ok(secure_only_ok)
  );

  // Set/clear bitmaps
  logic [NBM-1:0]              set_v, clr_v, bm_chg;
  logic [NBM-1:0][NUM_IRQ-1:0] bm_q;

  always_comb begin
    set_v = {wr && sel == SEL_AC_SET, wr && sel == SEL_PD_SET, wr && sel == SEL_EN_SET};
    clr_v = {wr && sel == SEL_AC_CLR, wr && sel == SEL_PD_CLR, wr && sel == SEL_EN_CLR};
  end

  for (genvar g = 0; g < NBM; g++) begin : g_bm
    irqb_setclr_bitmap #(.N(NUM_IRQ)) u_bm (
      .clk(clk), .rst_n(rst_int_n), .set_en(set_v[g]), .clr_en(clr_v[g]),
      .wbits(req_wdata), .mask(mask), .bits_q(bm_q[g]), .changed(bm_chg[g])
    );
  end

  // Edge/level configuration
  logic [NUM_IRQ-1:0] edge_q, cfg_rd_lo, cfg_rd_hi;
  logic               cfg_chg;
  irqb_cfg_bank #(.N(NUM_IRQ)) u_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_hi(wr && sel == SEL_CFG_HI),
    .wdata(req_wdata), .mask(mask), .edge_q(edge_q),
    .rd_lo(cfg_rd_lo), .rd_hi(cfg_rd_hi), .changed(cfg_chg)
  );

  // Group, group modifier, non-secure access registers
  logic               grp_we, gmod_we, nsac_we;
  logic [NUM_IRQ-1:0] group_d, grpmod_d, nsac_d;

  always_comb begin
    grp_we   = wr && sel == SEL_GROUP && !ns_limited;
    gmod_we  = wr && sel == SEL_GMOD  && secure_only_ok;
    nsac_we  = wr && sel == SEL_NSAC  && secure_only_ok;
    group_d  = grp_we  ? req_wdata : group_q;
    grpmod_d = gmod_we ? req_wdata : grpmod_q;
    nsac_d   = nsac_we ? req_wdata : nsac_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      group_q  <= '0;
      grpmod_q <= '0;
      nsac_q   <= '0;
    end else begin
      if (grp_we)  group_q  <= group_d;
      if (gmod_we) grpmod_q <= grpmod_d;
      if (nsac_we) nsac_q   <= nsac_d;
    end
  end

  // Effective pending: latch or live level of level-sensitive inputs
  logic [NUM_IRQ-1:0] pend_eff;
  assign pend_eff = bm_q[1] | (irq_level & ~edge_q);

  // Read mux
  logic [NUM_IRQ-1:0] rd_data;
  logic               bad;
  always_comb begin
    bad     = req_valid && (sel == SEL_NONE);
    rd_data = '0;
    if (rd) begin
      case (sel)
        SEL_GROUP:              rd_data = ns_limited ? '0 : group_q;
        SEL_EN_SET, SEL_EN_CLR: rd_data = bm_q[0] & mask;
        SEL_PD_SET, SEL_PD_CLR: rd_data = pend_eff & mask;
        SEL_AC_SET, SEL_AC_CLR: rd_data = bm_q[2] & mask;
        SEL_CFG_LO:             rd_data = cfg_rd_lo;
        SEL_CFG_HI:             rd_data = cfg_rd_hi;
        SEL_GMOD:               rd_data = secure_only_ok ? grpmod_q : '0;
        SEL_NSAC:               rd_data = secure_only_ok ? nsac_q : '0;
        default:                rd_data = '0;
      endcase
    end
  end

  logic upd_d;
  assign upd_d = (|bm_chg) || cfg_chg || (group_d != group_q) || (grpmod_d != grpmod_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      update_o  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_data;
      rsp_err   <= bad;
      update_o  <= upd_d;
    end
  end

  assign enable_o  = bm_q[0];
  assign pending_o = pend_eff;
  assign active_o  = bm_q[2];
  assign group_o   = group_q;
  assign grpmod_o  = grpmod_q;
  assign edge_o    = edge_q;
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker
  import irqb_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_disable,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_secure,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [N-1:0]      enable_o,
  input logic [N-1:0]      group_o,
  input logic [N-1:0]      edge_o,
  input logic              update_o
);
  logic ns_wr;
  assign ns_wr = req_valid && req_write && !req_secure && !sec_disable;

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_group_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_wr && req_addr == OFF_GROUP) |=> (group_o == $past(group_o)));

  assert_set_keeps_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == OFF_EN_SET)
      |=> ((enable_o & $past(enable_o)) == $past(enable_o)));

  assert_clr_adds_nothing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == OFF_EN_CLR)
      |=> ((enable_o & ~$past(enable_o)) == '0));

  assert_ns_set_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_wr && req_addr == OFF_EN_SET)
      |=> ((enable_o & ~$past(enable_o) & ~$past(group_o)) == '0));

  assert_cfg_lo_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == OFF_CFG_LO) |=> $stable(edge_o));

  assert_no_update_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !update_o);
endmodule

bind irq_state_bank irqb_checker #(.N(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .sec_disable(sec_disable),
  .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .enable_o(enable_o),
  .group_o(group_o), .edge_o(edge_o), .update_o(update_o)
);

// File: tb/sim_irq_state_bank.sv
`timescale 1ns/1ps
module sim_irq_state_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sec_disable;
  logic [31:0] irq_level;
  logic        req_valid, req_write, req_secure;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err, update_o;
  logic [31:0] rsp_rdata, enable_o, pending_o, active_o, group_o, grpmod_o, edge_o;

  always #2 clk = ~clk;

  irq_state_bank u0 (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .irq_level(irq_level),
    .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .enable_o(enable_o),
    .pending_o(pending_o), .active_o(active_o), .group_o(group_o),
    .grpmod_o(grpmod_o), .edge_o(edge_o), .update_o(update_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Driver: one request, expectation queued for the monitor, strobe checked.
  task automatic acc(input logic wr, input logic sec, input logic [7:0] a,
                     input logic [31:0] wd, input logic [31:0] ed,
                     input logic ee, input logic eu, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_secure = sec; req_addr = a; req_wdata = wd;
    q_data.push_back(wr ? 32'h0 : ed);
    q_err.push_back(ee);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    check({tag, " update"}, {31'h0, update_o}, {31'h0, eu});
  endtask

  // Monitor: compares responses against queued expectations.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8: unexpected response actual 0x%08h expected none", rsp_rdata);
      end else begin
        automatic logic [31:0] d = q_data.pop_front();
        automatic logic        e = q_err.pop_front();
        automatic string       t = q_tag.pop_front();
        check({t, " data"}, rsp_rdata, d);
        check({t, " err"}, {31'h0, rsp_err}, {31'h0, e});
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_disable = 1'b0; irq_level = '0;
    req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    check("R9 enable", enable_o, 32'h0);
    check("R9 pending", pending_o, 32'h0);
    check("R9 active", active_o, 32'h0);
    check("R9 group", group_o, 32'h0);
    check("R9 edge", edge_o, 32'h0000FFFF);
    check("R9 rsp idle", {31'h0, rsp_valid}, 32'h0);
    acc(0, 1, 8'h1C, 0, 32'hAAAAAAAA, 0, 0, "R6 cfg lo reset");
    acc(0, 1, 8'h20, 0, 32'h0, 0, 0, "R9 cfg hi reset");
    acc(0, 1, 8'h24, 0, 32'h0, 0, 0, "R9 gmod reset");

    // R4 group access
    acc(1, 1, 8'h00, 32'h0000FF0F, 0, 0, 1, "R4 secure group write");
    acc(0, 1, 8'h00, 0, 32'h0000FF0F, 0, 0, "R4 secure group read");
    acc(0, 0, 8'h00, 0, 32'h0, 0, 0, "R4 ns group read");
    acc(1, 0, 8'h00, 32'hFFFFFFFF, 0, 0, 0, "R4 ns group write ignored");
    acc(0, 1, 8'h00, 0, 32'h0000FF0F, 0, 0, "R4 group kept");

    // R1/R2 enable set and clear
    acc(1, 0, 8'h04, 32'hFFFFFFFF, 0, 0, 1, "R1 ns enable set");
    check("R1 enable after ns set", enable_o, 32'h0000FF0F);
    acc(1, 1, 8'h04, 32'h00F00000, 0, 0, 1, "R2 secure enable set");
    acc(0, 1, 8'h08, 0, 32'h00F0FF0F, 0, 0, "R2 clear view reads bitmap");
    acc(0, 0, 8'h04, 0, 32'h0000FF0F, 0, 0, "R1 ns enable read masked");
    acc(1, 0, 8'h08, 32'hFFFFFFFF, 0, 0, 1, "R1 ns enable clear");
    acc(0, 1, 8'h04, 0, 32'h00F00000, 0, 0, "R2 enable after clear");

    // R3 pending with live level
    irq_level = 32'h00030001;
    acc(0, 1, 8'h0C, 0, 32'h00030000, 0, 0, "R3 level merged");
    check("R3 pending_o level", pending_o, 32'h00030000);
    acc(0, 0, 8'h10, 0, 32'h0, 0, 0, "R1 ns pending read masked");
    acc(1, 1, 8'h10, 32'hFFFFFFFF, 0, 0, 0, "R10 clear with no change");
    acc(0, 1, 8'h10, 0, 32'h00030000, 0, 0, "R3 level survives clear");

    // R6/R7 configuration
    acc(1, 1, 8'h20, 32'h00000002, 0, 0, 1, "R7 cfg hi write");
    acc(0, 1, 8'h0C, 0, 32'h00020000, 0, 0, "R3 edge irq drops level");
    acc(0, 1, 8'h20, 0, 32'h00000002, 0, 0, "R6 cfg hi read");
    acc(1, 1, 8'h1C, 32'h0, 0, 0, 0, "R7 cfg lo write ignored");
    acc(0, 1, 8'h1C, 0, 32'hAAAAAAAA, 0, 0, "R7 cfg lo unchanged");
    acc(1, 0, 8'h20, 32'hFFFFFFFF, 0, 0, 0, "R7 ns cfg hi masked out");
    acc(0, 1, 8'h20, 0, 32'h00000002, 0, 0, "R7 cfg hi kept");
    acc(1, 1, 8'h00, 32'h00FFFF0F, 0, 0, 1, "R4 group widen");
    acc(1, 0, 8'h20, 32'hAAAAAAAA, 0, 0, 1, "R7 ns cfg hi partial");
    acc(0, 1, 8'h20, 0, 32'h0000AAAA, 0, 0, "R6 cfg hi partial read");
    acc(0, 0, 8'h1C, 0, 32'hAAAA00AA, 0, 0, "R1 ns cfg lo masked");
    check("R7 edge_o", edge_o, 32'h00FFFFFF);
    check("R3 pending_o all edge", pending_o, 32'h0);

    // Active bitmap
    acc(1, 1, 8'h14, 32'h80000001, 0, 0, 1, "R2 active set");
    acc(0, 1, 8'h18, 0, 32'h80000001, 0, 0, "R2 active clear view");
    acc(1, 0, 8'h18, 32'hFFFFFFFF, 0, 0, 1, "R1 ns active clear");
    acc(0, 1, 8'h14, 0, 32'h80000000, 0, 0, "R1 active secure bit kept");
    check("R2 active_o", active_o, 32'h80000000);

    // R5 secure-only registers
    acc(1, 0, 8'h24, 32'h5, 0, 0, 0, "R5 ns gmod write ignored");
    acc(1, 1, 8'h24, 32'h5, 0, 0, 1, "R5 secure gmod write");
    acc(0, 1, 8'h24, 0, 32'h5, 0, 0, "R5 gmod read");
    acc(0, 0, 8'h24, 0, 32'h0, 0, 0, "R5 ns gmod read zero");
    acc(1, 1, 8'h28, 32'h3, 0, 0, 0, "R5 nsac write");
    acc(0, 1, 8'h28, 0, 32'h3, 0, 0, "R5 nsac read");
    acc(0, 0, 8'h28, 0, 32'h0, 0, 0, "R5 ns nsac read zero");
    check("R5 grpmod_o", grpmod_o, 32'h5);

    // Security disabled
    sec_disable = 1'b1;
    acc(0, 1, 8'h24, 0, 32'h0, 0, 0, "R5 gmod hidden when disabled");
    acc(0, 0, 8'h00, 0, 32'h00FFFF0F, 0, 0, "R4 ns group visible when disabled");
    acc(0, 0, 8'h04, 0, 32'h00F00000, 0, 0, "R1 ns full mask when disabled");
    acc(1, 1, 8'h24, 32'h7, 0, 0, 0, "R5 gmod write ignored when disabled");
    sec_disable = 1'b0;
    acc(0, 1, 8'h24, 0, 32'h5, 0, 0, "R5 gmod kept");

    // R8 unknown offsets
    acc(0, 1, 8'h40, 0, 32'h0, 1, 0, "R8 unknown read");
    acc(1, 1, 8'h40, 32'hFFFFFFFF, 0, 1, 0, "R8 unknown write");
    acc(0, 1, 8'h06, 0, 32'h0, 1, 0, "R8 misaligned read");

    // Edge interrupt pending latch
    irq_level = '0;
    acc(1, 1, 8'h0C, 32'h00010000, 0, 0, 1, "R2 pending set edge irq");
    acc(0, 1, 8'h0C, 0, 32'h00010000, 0, 0, "R2 pending latch read");
    check("R3 pending_o latch", pending_o, 32'h00010000);

    repeat (3) @(negedge clk);
    checks++;
    if (q_data.size() != 0) begin
      fails++;
      $display("FAIL R8: actual %0d pending responses expected 0", q_data.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule